// File: doc/BRIEF.md
# Timer Interrupt Status and Enable Register

This block gathers one-cycle expiry pulses from a set of timer channels into a single register word. The word holds a per-channel interrupt enable field and a per-channel sticky status field. It drives one registered interrupt line per channel. Software reads the whole word at once. A write replaces the enable field and clears any status bits written as one. With the default of five channels, the enables sit in bits 4:0, the status flags sit in bits 9:5, and every higher bit reads as zero.

A status bit records every expiry, whether or not that channel is enabled, so software can poll a masked channel. An interrupt line rises only when its channel expires while enabled. It then stays high until software clears the matching status bit. This makes the line a level request for a downstream interrupt controller.

Top module: `tmr_irq_stat`

## Requirements
- R1: After reset is released, rd_data_o reads 0 and every irq_o line is low.
- R2: rd_data_o bits N_CH-1:0 show the enable field. Bits 2*N_CH-1:N_CH show the status field, with channel n at bit N_CH+n (default: 5+n).
- R3: An expire_i[n] pulse sets status bit n at the next clock edge, whether or not enable n is set.
- R4: An expire_i[n] pulse asserts irq_o[n] from the next clock edge when enable n, as held before that edge, is 1.
- R5: A write (wr_en_i high) loads wr_data_i[N_CH-1:0] into the enable field at that edge.
- R6: On a write, a 1 in status bit position N_CH+n clears status bit n, and a 0 leaves it unchanged.
- R7: Clearing status bit n deasserts irq_o[n] at the same edge. irq_o[n] is never high while status bit n is low.
- R8: When an expiry and a write-one-to-clear reach the same status bit in one cycle, the bit ends up set.
- R9: Bits DW-1:2*N_CH read as zero, and writing ones to them changes nothing.
- R10: An asserted irq_o[n] stays high until status bit n is cleared, even if enable n is cleared meanwhile. Setting enable n while status n is already pending does not assert irq_o[n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | DW (32) | Write data |
| expire_i | input | N_CH (5) | One-cycle expiry pulse per channel |
| rd_data_o | output | DW (32) | Register read value |
| irq_o | output | N_CH (5) | Registered interrupt level per channel |

## Verification
The bench builds the block with its defaults: five channels and a 32-bit word. This places the highest status flag at bit 9, with 22 unused upper bits above it, so the boundary between the status field and the zero field is exercised directly. The vector sequence makes an expiry coincide with a clear on the same bit. It also masks a channel while its line is high, and enables a channel that already has a pending flag. These orderings pin down the set-wins rule and the rule that a line follows expiry events rather than the enable level.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int unsigned DEF_N_CH = 5;
  localparam int unsigned DEF_DW   = 32;
endpackage

// File: rtl/tmr_irq_en_reg.sv
module tmr_irq_en_reg #(
  parameter int unsigned N_CH = tmr_irq_pkg::DEF_N_CH
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [N_CH-1:0] wd_i,
  output logic [N_CH-1:0] en_o
);
  logic [N_CH-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (wr_i) en_q <= wd_i;
  end

  assign en_o = en_q;

  assert_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> en_o == $past(wd_i));
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(en_o));
endmodule

// File: rtl/tmr_irq_chan.sv
module tmr_irq_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic en_i,
  input  logic clr_i,
  output logic stat_o,
  output logic irq_o
);
  logic stat_q, irq_q;
  logic stat_d, irq_d;

  always_comb begin
    // set has priority over write-one-to-clear
    stat_d = expire_i | (stat_q & ~clr_i);
    // line rises only on an enabled expiry, falls only with its status
    irq_d  = stat_d & ((expire_i & en_i) | irq_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= irq_d;
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = irq_q;

  assert_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> stat_o);
  assert_irq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i && en_i |=> irq_o);
  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !expire_i |=> !stat_o);
  assert_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && stat_o |=> stat_o);
  assert_irq_needs_stat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> stat_o);
  assert_no_spurious_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o && !(expire_i && en_i) |=> !irq_o);
  assert_irq_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !clr_i |=> irq_o);
endmodule

// File: rtl/tmr_irq_stat.sv
module tmr_irq_stat #(
  parameter int unsigned N_CH = tmr_irq_pkg::DEF_N_CH,
  parameter int unsigned DW   = tmr_irq_pkg::DEF_DW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic [N_CH-1:0] expire_i,
  output logic [DW-1:0]   rd_data_o,
  output logic [N_CH-1:0] irq_o
);
  localparam int unsigned ST_LSB = N_CH;
  localparam int unsigned ST_MSB = 2 * N_CH - 1;

  logic [N_CH-1:0] en, stat, clr;

  tmr_irq_en_reg #(.N_CH(N_CH)) u_en (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (wr_en_i),
    .wd_i  (wr_data_i[N_CH-1:0]),
    .en_o  (en)
  );

  assign clr = {N_CH{wr_en_i}} & wr_data_i[ST_MSB:ST_LSB];

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    tmr_irq_chan u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .expire_i(expire_i[g]),
      .en_i    (en[g]),
      .clr_i   (clr[g]),
      .stat_o  (stat[g]),
      .irq_o   (irq_o[g])
    );
  end

  always_comb begin
    rd_data_o                = '0;
    rd_data_o[N_CH-1:0]      = en;
    rd_data_o[ST_MSB:ST_LSB] = stat;
  end

  assert_upper_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(rd_data_o[DW-1:ST_MSB+1]));
endmodule

// File: tb/sim_tmr_irq_stat.sv
module sim_tmr_irq_stat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] wd = '0;
  logic [4:0]  ex = '0;
  logic [31:0] rd;
  logic [4:0]  irq;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  tmr_irq_stat u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .wr_data_i(wd),
    .expire_i(ex), .rd_data_o(rd), .irq_o(irq)
  );

  // {wr, wdata[9:0], expire[4:0], exp_rd[9:0], exp_irq[4:0]}
  localparam int NV = 12;
  localparam logic [30:0] VEC [NV] = '{
    {1'b0, 10'h000, 5'h00, 10'h000, 5'h00}, // R1 idle
    {1'b0, 10'h000, 5'h01, 10'h020, 5'h00}, // R3 masked expiry
    {1'b1, 10'h003, 5'h00, 10'h023, 5'h00}, // R5 R10 enable pending
    {1'b0, 10'h000, 5'h02, 10'h063, 5'h02}, // R4 R2
    {1'b1, 10'h023, 5'h00, 10'h043, 5'h02}, // R6 clear ch0
    {1'b1, 10'h000, 5'h00, 10'h040, 5'h02}, // R10 mask keeps line
    {1'b1, 10'h040, 5'h00, 10'h000, 5'h00}, // R7
    {1'b1, 10'h01F, 5'h00, 10'h01F, 5'h00}, // R5
    {1'b0, 10'h000, 5'h1C, 10'h39F, 5'h1C}, // R4 top channel
    {1'b1, 10'h09F, 5'h04, 10'h39F, 5'h1C}, // R8 set wins
    {1'b1, 10'h31F, 5'h00, 10'h09F, 5'h04}, // R6 R7
    {1'b1, 10'h3FF, 5'h00, 10'h01F, 5'h00}  // R6 clear all
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [31:0] d, input logic [4:0] e);
    wr = w; wd = d; ex = e;
    @(negedge clk);
    wr = 1'b0; wd = '0; ex = '0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rd", rd, 32'h0);
    check("R1 irq", {27'h0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][30], {22'h0, VEC[i][29:20]}, VEC[i][19:15]);
      check($sformatf("R2 vec%0d rd", i), rd, {22'h0, VEC[i][14:5]});
      check($sformatf("R4 vec%0d irq", i), {27'h0, irq}, {27'h0, VEC[i][4:0]});
    end

    // R9: upper ones ignored, enables cleared, status untouched
    step(1'b0, 32'h0, 5'h10);
    step(1'b1, 32'hFFFF_FC1F, 5'h00);
    check("R9 rd", rd, 32'h0000_021F);
    check("R9 irq", {27'h0, irq}, 32'h10);
    step(1'b1, 32'hFFFF_FC00, 5'h00);
    check("R9 upper zero", rd, 32'h0000_0200);
    check("R10 irq held after mask", {27'h0, irq}, 32'h10);

    // R1: reset in mid-run returns everything to zero
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rd after reset", rd, 32'h0);
    check("R1 irq after reset", {27'h0, irq}, 32'h0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule